// File: doc/BRIEF.md
# Priority Port-Pin Crossbar Allocator

This block connects thirteen digital peripheral signals to an eight-pin port. A serial transmit/receive pair sits on fixed pins 4 and 5 whenever that function is on. Every other enabled signal is handled in a fixed priority order and takes the lowest-numbered pin that is still free. A software skip mask lets some pins be kept back for analog use or plain GPIO. The search treats a skipped pin as already taken.

The pin assignment is combinational from four configuration registers, which are loaded through a small write port. Registered outputs give three results. Each pin drives either its owning peripheral's output value and output enable, or a GPIO value and direction. Each peripheral input reads back from the pin assigned to it. Each signal reports its pin index and a valid flag.

Signal indices, used in every per-signal vector: 0 serial TX, 1 serial RX, 2 I2C data, 3 I2C clock, 4 comparator out, 5 comparator async out, 6 system clock out, 7/8/9 capture-compare 0/1/2, 10 counter clock in, 11 timer 0 in, 12 timer 1 in. Enable register bits: bit 0 is the serial pair, and bit k (k = 1..11) is signal k+1.

Top module: `pin_xbar`

## Requirements
- R1: After reset, the configuration and output registers read as follows. Skip mask, enables, GPIO value and GPIO direction are all 0. Every pin_o and pin_oe is 0, every sig_valid is 0, every sig_pin field is 0 and every periph_i is 1.
- R2: When enable bit 0 is set, signal 0 gets pin 4 and signal 1 gets pin 5, and both are valid. This holds whatever the skip mask holds.
- R3: Signals 2 to 12 are taken in index order (lowest index first). Each enabled one gets the lowest pin that is not already taken. With mask 0 and the serial pair off, the enabled signals pack into pins 0, 1, 2 and so on. With the pair on, pins 4 and 5 are left out of that packing.
- R4: A pin whose skip-mask bit is set is never given to signals 2 to 12. With mask 0x44, pins 2 and 6 stay unassigned.
- R5: No pin is owned by more than one signal.
- R6: A disabled signal has sig_valid 0. It does not move the pin of any lower-priority signal.
- R7: An enabled signal that finds no free pin has sig_valid 0 and sig_pin 0, and it drives no pin.
- R8: periph_i[s] equals pin_i at the pin assigned to signal s. When signal s has no pin, periph_i[s] is 1.
- R9: A pin owned by no signal drives its GPIO value register bit on pin_o and its GPIO direction register bit on pin_oe.
- R10: A pin owned by signal s drives periph_o[s] on pin_o and periph_oe[s] on pin_oe.
- R11: A write is taken on a clock edge when wr_en is 1. The value comes from wr_data and the target from wr_addr: 0 skip mask (data bits 7:0), 1 enables (data bits 11:0), 2 GPIO value (bits 7:0), 3 GPIO direction (bits 7:0). Outputs show a write taken at edge N from edge N+1 onward. They show input changes one edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 12 | Write data |
| periph_o | input | 13 | Peripheral output values, one per signal |
| periph_oe | input | 13 | Peripheral output enables, one per signal |
| pin_i | input | 8 | Pad input values |
| pin_o | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| periph_i | output | 13 | Peripheral input values, routed from pins |
| sig_pin | output | 39 | Pin index per signal, 3 bits each, signal s at bits 3s+2:3s |
| sig_valid | output | 13 | Signal has a pin |

## Verification
Some properties are checked on every clock cycle: the fixed serial pins when the pair is on, skipped pins never being granted, at most one owner per pin, disabled signals holding no pin, and inputs without a pin idling high. Other behaviour needs the bench's scenarios against an independent model. That covers whether the assignment really is the lowest free pin in priority order, how it behaves when pins run out, the output and input routing for chosen values, and the one-edge latency after a write.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int NSIG  = 13;
  localparam int NFUNC = 12;
  localparam int FUNC_SERIAL = 0;

  localparam logic [1:0] ADDR_SKIP = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_GPO  = 2'd2;
  localparam logic [1:0] ADDR_GDIR = 2'd3;

  // enable bit governing a signal index
  function automatic int func_of(input int s);
    return (s < 2) ? FUNC_SERIAL : s - 1;
  endfunction
endpackage

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs #(
  parameter int NPIN  = 8,
  parameter int NFUNC = 12,
  parameter int DW    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [NPIN-1:0]  skip_q,
  output logic [NFUNC-1:0] en_q,
  output logic [NPIN-1:0]  gpo_q,
  output logic [NPIN-1:0]  gdir_q
);
  import pin_xbar_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_q <= '0;
      en_q   <= '0;
      gpo_q  <= '0;
      gdir_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_SKIP: skip_q <= wr_data[NPIN-1:0];
        ADDR_EN:   en_q   <= wr_data[NFUNC-1:0];
        ADDR_GPO:  gpo_q  <= wr_data[NPIN-1:0];
        default:   gdir_q <= wr_data[NPIN-1:0];
      endcase
    end
  end
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc #(
  parameter int NPIN   = 8,
  parameter int NSIG   = 13,
  parameter int NFUNC  = 12,
  parameter int TX_PIN = 4,
  parameter int RX_PIN = 5,
  parameter int PW     = 3
) (
  input  logic [NPIN-1:0]          skip,
  input  logic [NFUNC-1:0]         en,
  output logic [NSIG-1:0][PW-1:0]  sig_pin,
  output logic [NSIG-1:0]          sig_valid
);
  logic [NPIN-1:0] taken;
  logic            found;

  always_comb begin
    taken     = skip;
    sig_pin   = '0;
    sig_valid = '0;
    found     = 1'b0;
    if (en[0]) begin
      taken[TX_PIN] = 1'b1;
      taken[RX_PIN] = 1'b1;
      sig_valid[0]  = 1'b1;
      sig_valid[1]  = 1'b1;
      sig_pin[0]    = PW'(TX_PIN);
      sig_pin[1]    = PW'(RX_PIN);
    end
    for (int s = 2; s < NSIG; s++) begin
      found = 1'b0;
      if (en[s-1]) begin
        for (int p = 0; p < NPIN; p++) begin
          if (!found && !taken[p]) begin
            found        = 1'b1;
            taken[p]     = 1'b1;
            sig_valid[s] = 1'b1;
            sig_pin[s]   = PW'(p);
          end
        end
      end
    end
  end
endmodule

// File: rtl/xbar_route.sv
module xbar_route #(
  parameter int NPIN = 8,
  parameter int NSIG = 13,
  parameter int PW   = 3
) (
  input  logic [NSIG-1:0][PW-1:0]   sig_pin,
  input  logic [NSIG-1:0]           sig_valid,
  input  logic [NSIG-1:0]           periph_o,
  input  logic [NSIG-1:0]           periph_oe,
  input  logic [NPIN-1:0]           gpo,
  input  logic [NPIN-1:0]           gdir,
  input  logic [NPIN-1:0]           pin_i,
  output logic [NPIN-1:0][NSIG-1:0] claim,
  output logic [NPIN-1:0]           pin_o_c,
  output logic [NPIN-1:0]           pin_oe_c,
  output logic [NSIG-1:0]           periph_i_c
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    for (genvar s = 0; s < NSIG; s++) begin : g_hit
      assign claim[p][s] = sig_valid[s] && (sig_pin[s] == PW'(p));
    end

    always_comb begin
      pin_o_c[p]  = gpo[p];
      pin_oe_c[p] = gdir[p];
      for (int s = NSIG - 1; s >= 0; s--) begin
        if (claim[p][s]) begin
          pin_o_c[p]  = periph_o[s];
          pin_oe_c[p] = periph_oe[s];
        end
      end
    end
  end

  for (genvar s = 0; s < NSIG; s++) begin : g_in
    assign periph_i_c[s] = sig_valid[s] ? pin_i[sig_pin[s]] : 1'b1;
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar #(
  parameter int NPIN   = 8,
  parameter int TX_PIN = 4,
  parameter int RX_PIN = 5,
  localparam int NSIG  = pin_xbar_pkg::NSIG,
  localparam int NFUNC = pin_xbar_pkg::NFUNC,
  localparam int PW    = $clog2(NPIN),
  localparam int DW    = (NFUNC > NPIN) ? NFUNC : NPIN
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [NSIG-1:0]      periph_o,
  input  logic [NSIG-1:0]      periph_oe,
  input  logic [NPIN-1:0]      pin_i,
  output logic [NPIN-1:0]      pin_o,
  output logic [NPIN-1:0]      pin_oe,
  output logic [NSIG-1:0]      periph_i,
  output logic [NSIG*PW-1:0]   sig_pin,
  output logic [NSIG-1:0]      sig_valid
);
  import pin_xbar_pkg::*;

  logic [NPIN-1:0]           skip_q, gpo_q, gdir_q;
  logic [NFUNC-1:0]          en_q;
  logic [NSIG-1:0][PW-1:0]   pin_c, pin_q;
  logic [NSIG-1:0]           valid_c;
  logic [NPIN-1:0][NSIG-1:0] claim;
  logic [NPIN-1:0]           pin_o_c, pin_oe_c;
  logic [NSIG-1:0]           periph_i_c;

  xbar_cfg_regs #(.NPIN(NPIN), .NFUNC(NFUNC), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .skip_q(skip_q), .en_q(en_q), .gpo_q(gpo_q), .gdir_q(gdir_q)
  );

  xbar_alloc #(.NPIN(NPIN), .NSIG(NSIG), .NFUNC(NFUNC),
               .TX_PIN(TX_PIN), .RX_PIN(RX_PIN), .PW(PW)) u_alloc (
    .skip(skip_q), .en(en_q), .sig_pin(pin_c), .sig_valid(valid_c)
  );

  xbar_route #(.NPIN(NPIN), .NSIG(NSIG), .PW(PW)) u_route (
    .sig_pin(pin_c), .sig_valid(valid_c), .periph_o(periph_o),
    .periph_oe(periph_oe), .gpo(gpo_q), .gdir(gdir_q), .pin_i(pin_i),
    .claim(claim), .pin_o_c(pin_o_c), .pin_oe_c(pin_oe_c),
    .periph_i_c(periph_i_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o     <= '0;
      pin_oe    <= '0;
      periph_i  <= '1;
      pin_q     <= '0;
      sig_valid <= '0;
    end else begin
      pin_o     <= pin_o_c;
      pin_oe    <= pin_oe_c;
      periph_i  <= periph_i_c;
      pin_q     <= pin_c;
      sig_valid <= valid_c;
    end
  end

  assign sig_pin = pin_q;

  AST_SERIAL_FIXED: assert property (@(posedge clk) disable iff (rst)
    en_q[FUNC_SERIAL] |-> (valid_c[0] && valid_c[1] &&
      pin_c[0] == PW'(TX_PIN) && pin_c[1] == PW'(RX_PIN))); // R2

  for (genvar s = 0; s < NSIG; s++) begin : g_sig_chk
    AST_DISABLED_NO_PIN: assert property (@(posedge clk) disable iff (rst)
      !en_q[func_of(s)] |-> !valid_c[s]); // R6
    AST_IDLE_INPUT_HIGH: assert property (@(posedge clk) disable iff (rst)
      !sig_valid[s] |-> periph_i[s]); // R8
    if (s >= 2) begin : g_pack
      AST_SKIP_HONORED: assert property (@(posedge clk) disable iff (rst)
        valid_c[s] |-> !skip_q[pin_c[s]]); // R4
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin_chk
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
      $countones(claim[p]) <= 1); // R5
  end
endmodule

// File: tb/pin_xbar_bench.sv
module pin_xbar_bench;
  localparam int NPIN = 8;
  localparam int NSIG = 13;
  localparam int PW   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [NSIG-1:0] periph_o = '0, periph_oe = '0;
  logic [NPIN-1:0] pin_i = '0;
  logic [NPIN-1:0] pin_o, pin_oe;
  logic [NSIG-1:0] periph_i, sig_valid;
  logic [NSIG*PW-1:0] sig_pin;

  always #4 clk = ~clk;

  pin_xbar u_pin_xbar (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .periph_o(periph_o), .periph_oe(periph_oe), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe), .periph_i(periph_i),
    .sig_pin(sig_pin), .sig_valid(sig_valid)
  );

  typedef struct {
    string              tag;
    logic [NPIN-1:0]    po, poe;
    logic [NSIG-1:0]    val, pi;
    logic [NSIG*PW-1:0] pins;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench shadow of the configuration
  logic [7:0]  m_skip = '0, m_gpo = '0, m_gdir = '0;
  logic [11:0] m_en = '0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic exp_t model(string tag);
    exp_t e;
    logic [NPIN-1:0] used;
    int owner [NPIN];
    e.tag = tag; e.val = '0; e.pins = '0; e.pi = '1;
    used = m_skip;
    for (int p = 0; p < NPIN; p++) owner[p] = -1;
    if (m_en[0]) begin
      e.val[0] = 1; e.pins[0*PW +: PW] = 3'd4; owner[4] = 0;
      e.val[1] = 1; e.pins[1*PW +: PW] = 3'd5; owner[5] = 1;
      used[4] = 1; used[5] = 1;
    end
    for (int s = 2; s < NSIG; s++) begin
      if (m_en[s-1]) begin
        for (int p = 0; p < NPIN; p++) begin
          if (!e.val[s] && !used[p]) begin
            e.val[s] = 1; e.pins[s*PW +: PW] = PW'(p); used[p] = 1; owner[p] = s;
          end
        end
      end
    end
    for (int p = 0; p < NPIN; p++) begin
      e.po[p]  = (owner[p] < 0) ? m_gpo[p]  : periph_o[owner[p]];
      e.poe[p] = (owner[p] < 0) ? m_gdir[p] : periph_oe[owner[p]];
      if (owner[p] >= 0) e.pi[owner[p]] = pin_i[p];
    end
    return e;
  endfunction

  task automatic wr(logic [1:0] a, logic [11:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    case (a)
      2'd0: m_skip = d[7:0];
      2'd1: m_en = d;
      2'd2: m_gpo = d[7:0];
      default: m_gdir = d[7:0];
    endcase
    @(negedge clk);
    wr_en = 0;
  endtask

  // driver: let the design settle, push the expected result, wait for the monitor
  task automatic expect_now(string tag);
    repeat (3) @(posedge clk);
    q.push_back(model(tag));
    wait (q.size() == 0);
    @(posedge clk);
  endtask

  // monitor
  exp_t cur;
  always @(negedge clk) begin
    if (q.size() != 0) begin
      cur = q.pop_front();
      chk({cur.tag, " valid"},    64'(sig_valid), 64'(cur.val));
      chk({cur.tag, " pin"},      64'(sig_pin),   64'(cur.pins));
      chk({cur.tag, " pin_o"},    64'(pin_o),     64'(cur.po));
      chk({cur.tag, " pin_oe"},   64'(pin_oe),    64'(cur.poe));
      chk({cur.tag, " periph_i"}, 64'(periph_i),  64'(cur.pi));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1 reset state
    q.push_back(model("R1 reset"));
    wait (q.size() == 0);

    // R3 R7: pair off, mask 0, everything else on -> pins 0..7 for signals 2..9
    periph_o = 13'h1555; periph_oe = 13'h1FFF;
    wr(2'd1, 12'hFFE);
    expect_now("R3 R7 pack no serial");

    // R2 R3 R7: pair on, pins 4,5 left out of packing
    wr(2'd1, 12'hFFF);
    expect_now("R2 R3 R7 serial on");

    // R4: mask 0x44 with pair on, I2C data, I2C clock, capture 0
    wr(2'd0, 12'h044);
    wr(2'd1, 12'h04F & 12'h047);
    expect_now("R4 mask 0x44");
    wr(2'd1, 12'hFFE);
    expect_now("R4 mask 0x44 full");

    // R2: serial pins fixed even under a mask covering them
    wr(2'd0, 12'h030);
    wr(2'd1, 12'h003);
    expect_now("R2 under mask");

    // R6: I2C clock and capture 1 only -> pins 0 and 1
    wr(2'd0, 12'h000);
    wr(2'd1, 12'h084);
    expect_now("R6 sparse enables");

    // R8 R9 R10: routing with GPIO registers
    wr(2'd2, 12'h0A5);
    wr(2'd3, 12'h0F0);
    wr(2'd1, 12'h202);
    periph_o = 13'h0004; periph_oe = 13'h0004; pin_i = 8'h01;
    expect_now("R8 R9 R10 route a");
    periph_o = 13'h0400; periph_oe = 13'h0000; pin_i = 8'hFE;
    expect_now("R8 R9 R10 route b");
    wr(2'd1, 12'h000);
    expect_now("R9 all gpio");

    // R11: write at edge N visible from edge N+1
    wr(2'd1, 12'h002);
    chk("R11 before update", 64'(sig_valid[2]), 64'd0);
    @(negedge clk);
    chk("R11 after update", 64'(sig_valid[2]), 64'd1);
    chk("R11 pin index", 64'(sig_pin[2*PW +: PW]), 64'd0);
    expect_now("R11 settled");

    finish_run();
  end
endmodule